// File: doc/BRIEF.md
# Lockup-Free Remote Line Cache

This block sits beside one cluster's local bus and keeps copies of memory lines whose home is another cluster. Each bus access whose address carries a remote cluster number is looked up in a direct-mapped array. A line held as shared or dirty answers at once. Otherwise the entry is claimed, marked as waiting, and a request goes out to the network. Later accesses keep being served while that request is in flight. The block never stalls the bus. It answers each remote access with one of three codes: hit, queued or retry.

Each entry is both the cached line and the tracker for the request that is still open on it. Agents that ask for a line that is already waiting join that entry's waiter set, and no second network request is sent. When the reply comes back, the waiting state is cleared, the line is stored, and one completion carries the waiter set and the line data back to the bus side. An access that lands on an index held by a different, still-waiting line is refused with retry. A dirty line displaced by another line is first sent home as a writeback.

Top module: `rac_top`

## Requirements
- R1: After reset, every output valid flag is low and every entry is invalid, so the first remote access to any line misses.
- R2: An access whose top CL_W address bits equal LOCAL_CL produces no response and no request and leaves every entry unchanged. Each remote access gets exactly one response (rsp_valid) in the next cycle, tagged with its agent.
- R3: A remote read to an index that is invalid, or that holds a different line in the shared state, answers queued (code 1) and issues a read request (kind 0) for the same line address in the same cycle as the response.
- R4: A reply that matches a line waiting for a read stores the reply data and makes the line shared. It raises done_valid with the waiter mask and the data. A later read of that line answers hit (code 0) with that data.
- R5: A read of a line that is already waiting, or a write to a line waiting for ownership, answers queued, issues no request, and its agent's bit appears in the done_mask of the eventual completion.
- R6: An access whose index holds a different line that is still waiting answers retry (code 2), issues no request, and leaves that entry intact so its own reply still completes.
- R7: Lines at different indices may wait at the same time, and their replies may return in any order.
- R8: A remote write miss issues an ownership request (kind 1) and holds the write data. Its reply makes the line dirty, and the completion carries the written data, not the reply data. A write to a dirty line answers hit and replaces the data.
- R9: A write to a shared line with a matching tag answers queued and issues an ownership request, and the line waits for ownership.
- R10: A write to a line that is waiting for a read answers retry and changes nothing.
- R11: An access whose index holds a different dirty line answers retry. It issues a writeback request (kind 2) with the displaced line's address and data, and invalidates the entry, so a repeat of the access then misses.
- R12: A reply whose line is not waiting at its index raises no completion and changes nothing.
- R13: A remote access to the same index as a reply arriving in the same cycle answers retry and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Snooped bus access present |
| bus_write | input | 1 | Access is a line write |
| bus_agent | input | AG_W | Requesting bus agent |
| bus_addr | input | ADDR_W | Line address; top CL_W bits name the home cluster |
| bus_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response to the access of the previous cycle |
| rsp_code | output | 2 | 0 hit, 1 queued, 2 retry |
| rsp_agent | output | AG_W | Agent being answered |
| rsp_data | output | DATA_W | Line data on a hit, else zero |
| req_valid | output | 1 | Network request issued |
| req_kind | output | 2 | 0 read, 1 ownership, 2 writeback |
| req_addr | output | ADDR_W | Line address of the request |
| req_data | output | DATA_W | Writeback data, else zero |
| rpl_valid | input | 1 | Network reply present |
| rpl_addr | input | ADDR_W | Line address of the reply |
| rpl_data | input | DATA_W | Reply line data |
| done_valid | output | 1 | Waiting line completed |
| done_mask | output | AGENTS | Agents that were waiting on the line |
| done_data | output | DATA_W | Line data after completion |

## Verification
The assertions assume that reset is held across the first edges, that at most one access and one reply are presented per cycle, and that bus_agent stays below AGENTS. The stimulus holds reset for several cycles and drives inputs only on the falling edge. It draws agents from the legal range and sends replies at any time, including replies to lines that are not waiting, which checks that such replies are ignored rather than assuming they cannot occur. A directed sequence covers each merge, retry and eviction case. A random phase then packs a few indices with clashing tags so that collisions with both waiting and dirty lines recur.

// File: rtl/rac_pkg.sv
package rac_pkg;

  typedef enum logic [2:0] {
    ST_INV = 3'd0,
    ST_PRD = 3'd1,
    ST_PWR = 3'd2,
    ST_SHR = 3'd3,
    ST_DRT = 3'd4
  } ent_st_e;

  typedef enum logic [1:0] {
    RSP_HIT    = 2'd0,
    RSP_QUEUED = 2'd1,
    RSP_RETRY  = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    REQ_READ   = 2'd0,
    REQ_OWN    = 2'd1,
    REQ_WRBACK = 2'd2
  } req_e;

  function automatic logic is_pending(ent_st_e s);
    return (s == ST_PRD) || (s == ST_PWR);
  endfunction

endpackage

// File: rtl/rac_store.sv
module rac_store
  import rac_pkg::*;
#(
  parameter int INDEX_W = 8,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 32,
  parameter int AGENTS  = 4
) (
  input  logic               clk,
  input  logic               rst,
  // lookup port for the bus side
  input  logic [INDEX_W-1:0] a_idx,
  output ent_st_e            a_st,
  output logic [TAG_W-1:0]   a_tag,
  output logic [AGENTS-1:0]  a_wtr,
  output logic [DATA_W-1:0]  a_data,
  // lookup port for the reply side
  input  logic [INDEX_W-1:0] b_idx,
  output ent_st_e            b_st,
  output logic [TAG_W-1:0]   b_tag,
  output logic [AGENTS-1:0]  b_wtr,
  output logic [DATA_W-1:0]  b_data,
  // bus-side update
  input  logic               wa_en,
  input  logic [INDEX_W-1:0] wa_idx,
  input  ent_st_e            wa_st,
  input  logic [TAG_W-1:0]   wa_tag,
  input  logic [AGENTS-1:0]  wa_wtr,
  input  logic [DATA_W-1:0]  wa_data,
  // reply-side update (tag kept, waiters cleared)
  input  logic               wb_en,
  input  logic [INDEX_W-1:0] wb_idx,
  input  ent_st_e            wb_st,
  input  logic [DATA_W-1:0]  wb_data
);
  localparam int DEPTH = 1 << INDEX_W;

  ent_st_e             st_q   [DEPTH];
  logic [TAG_W-1:0]    tag_m  [DEPTH];
  logic [AGENTS-1:0]   wtr_m  [DEPTH];
  logic [DATA_W-1:0]   data_m [DEPTH];

  // state bits need reset; payload arrays do not
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_INV;
    end else begin
      if (wb_en) st_q[wb_idx] <= wb_st;
      if (wa_en) st_q[wa_idx] <= wa_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wb_en) begin
      wtr_m[wb_idx]  <= '0;
      data_m[wb_idx] <= wb_data;
    end
    if (wa_en) begin
      tag_m[wa_idx]  <= wa_tag;
      wtr_m[wa_idx]  <= wa_wtr;
      data_m[wa_idx] <= wa_data;
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_m[a_idx];
  assign a_wtr  = wtr_m[a_idx];
  assign a_data = data_m[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_m[b_idx];
  assign b_wtr  = wtr_m[b_idx];
  assign b_data = data_m[b_idx];

endmodule

// File: rtl/rac_bus_ctl.sv
module rac_bus_ctl
  import rac_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int INDEX_W  = 8,
  parameter int DATA_W   = 32,
  parameter int AGENTS   = 4,
  parameter int CL_W     = 2,
  parameter int LOCAL_CL = 0,
  localparam int TAG_W   = ADDR_W - INDEX_W,
  localparam int AG_W    = (AGENTS > 1) ? $clog2(AGENTS) : 1
) (
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [AG_W-1:0]    bus_agent,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               rpl_valid,
  input  logic [INDEX_W-1:0] rpl_idx,
  input  ent_st_e            ent_st,
  input  logic [TAG_W-1:0]   ent_tag,
  input  logic [AGENTS-1:0]  ent_wtr,
  input  logic [DATA_W-1:0]  ent_data,
  output logic               act,
  output logic               wr_en,
  output ent_st_e            nx_st,
  output logic [TAG_W-1:0]   nx_tag,
  output logic [AGENTS-1:0]  nx_wtr,
  output logic [DATA_W-1:0]  nx_data,
  output rsp_e               o_code,
  output logic [DATA_W-1:0]  o_rdata,
  output logic               o_req,
  output req_e               o_kind,
  output logic [ADDR_W-1:0]  o_addr,
  output logic [DATA_W-1:0]  o_wbdata
);
  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   atag;
  logic [AGENTS-1:0]  abit;
  logic               tag_eq;

  assign idx    = bus_addr[INDEX_W-1:0];
  assign atag   = bus_addr[ADDR_W-1:INDEX_W];
  assign abit   = AGENTS'(1) << bus_agent;
  assign tag_eq = (ent_tag == atag);
  assign act    = bus_valid && (bus_addr[ADDR_W-1 -: CL_W] != LOCAL_CL[CL_W-1:0]);

  always_comb begin
    wr_en    = 1'b0;
    nx_st    = ent_st;
    nx_tag   = ent_tag;
    nx_wtr   = ent_wtr;
    nx_data  = ent_data;
    o_code   = RSP_RETRY;
    o_rdata  = '0;
    o_req    = 1'b0;
    o_kind   = REQ_READ;
    o_addr   = bus_addr;
    o_wbdata = '0;
    if (act && !(rpl_valid && rpl_idx == idx)) begin
      if (ent_st == ST_INV || (ent_st == ST_SHR && !tag_eq)) begin
        // claim the entry and open a request on it
        wr_en  = 1'b1;
        nx_tag = atag;
        nx_wtr = abit;
        o_code = RSP_QUEUED;
        o_req  = 1'b1;
        if (bus_write) begin
          nx_st   = ST_PWR;
          nx_data = bus_wdata;
          o_kind  = REQ_OWN;
        end else begin
          nx_st   = ST_PRD;
        end
      end else if (!tag_eq) begin
        if (ent_st == ST_DRT) begin
          wr_en    = 1'b1;
          nx_st    = ST_INV;
          o_req    = 1'b1;
          o_kind   = REQ_WRBACK;
          o_addr   = {ent_tag, idx};
          o_wbdata = ent_data;
        end
      end else begin
        unique case (ent_st)
          ST_SHR: begin
            if (bus_write) begin
              wr_en   = 1'b1;
              nx_st   = ST_PWR;
              nx_data = bus_wdata;
              nx_wtr  = abit;
              o_code  = RSP_QUEUED;
              o_req   = 1'b1;
              o_kind  = REQ_OWN;
            end else begin
              o_code  = RSP_HIT;
              o_rdata = ent_data;
            end
          end
          ST_DRT: begin
            o_code = RSP_HIT;
            if (bus_write) begin
              wr_en   = 1'b1;
              nx_data = bus_wdata;
              o_rdata = bus_wdata;
            end else begin
              o_rdata = ent_data;
            end
          end
          ST_PRD: begin
            if (!bus_write) begin
              wr_en  = 1'b1;
              nx_wtr = ent_wtr | abit;
              o_code = RSP_QUEUED;
            end
          end
          ST_PWR: begin
            wr_en  = 1'b1;
            nx_wtr = ent_wtr | abit;
            o_code = RSP_QUEUED;
            if (bus_write) nx_data = bus_wdata;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rac_fill.sv
module rac_fill
  import rac_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int AGENTS = 4
) (
  input  logic              rpl_valid,
  input  logic [TAG_W-1:0]  rpl_tag,
  input  logic [DATA_W-1:0] rpl_data,
  input  ent_st_e           ent_st,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [AGENTS-1:0] ent_wtr,
  input  logic [DATA_W-1:0] ent_data,
  output logic              wr_en,
  output ent_st_e           nx_st,
  output logic [DATA_W-1:0] nx_data,
  output logic [AGENTS-1:0] o_mask
);
  assign wr_en = rpl_valid && is_pending(ent_st) && (ent_tag == rpl_tag);

  always_comb begin
    if (ent_st == ST_PRD) begin
      nx_st   = ST_SHR;
      nx_data = rpl_data;
    end else begin
      nx_st   = ST_DRT;
      nx_data = ent_data;
    end
  end

  assign o_mask = ent_wtr;

endmodule

// File: rtl/rac_top.sv
module rac_top
  import rac_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int INDEX_W  = 8,
  parameter int DATA_W   = 32,
  parameter int AGENTS   = 4,
  parameter int CL_W     = 2,
  parameter int LOCAL_CL = 0,
  localparam int TAG_W   = ADDR_W - INDEX_W,
  localparam int AG_W    = (AGENTS > 1) ? $clog2(AGENTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [AG_W-1:0]   bus_agent,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [AG_W-1:0]   rsp_agent,
  output logic [DATA_W-1:0] rsp_data,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              rpl_valid,
  input  logic [ADDR_W-1:0] rpl_addr,
  input  logic [DATA_W-1:0] rpl_data,
  output logic              done_valid,
  output logic [AGENTS-1:0] done_mask,
  output logic [DATA_W-1:0] done_data
);
  logic [INDEX_W-1:0] bus_idx, rpl_idx;
  logic [TAG_W-1:0]   rpl_tag;

  ent_st_e             a_st, b_st, wa_st, wb_st;
  logic [TAG_W-1:0]    a_tag, b_tag, wa_tag;
  logic [AGENTS-1:0]   a_wtr, b_wtr, wa_wtr, f_mask;
  logic [DATA_W-1:0]   a_data, b_data, wa_data, wb_data;
  logic                wa_en, wb_en, act, c_req;
  rsp_e                c_code;
  req_e                c_kind;
  logic [DATA_W-1:0]   c_rdata, c_wbdata;
  logic [ADDR_W-1:0]   c_addr;

  assign bus_idx = bus_addr[INDEX_W-1:0];
  assign rpl_idx = rpl_addr[INDEX_W-1:0];
  assign rpl_tag = rpl_addr[ADDR_W-1:INDEX_W];

  rac_store #(
    .INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .AGENTS(AGENTS)
  ) u_store (
    .clk(clk), .rst(rst),
    .a_idx(bus_idx), .a_st(a_st), .a_tag(a_tag), .a_wtr(a_wtr), .a_data(a_data),
    .b_idx(rpl_idx), .b_st(b_st), .b_tag(b_tag), .b_wtr(b_wtr), .b_data(b_data),
    .wa_en(wa_en), .wa_idx(bus_idx), .wa_st(wa_st), .wa_tag(wa_tag),
    .wa_wtr(wa_wtr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(rpl_idx), .wb_st(wb_st), .wb_data(wb_data)
  );

  rac_bus_ctl #(
    .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W), .AGENTS(AGENTS),
    .CL_W(CL_W), .LOCAL_CL(LOCAL_CL)
  ) u_bus (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_agent(bus_agent),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rpl_valid(rpl_valid), .rpl_idx(rpl_idx),
    .ent_st(a_st), .ent_tag(a_tag), .ent_wtr(a_wtr), .ent_data(a_data),
    .act(act), .wr_en(wa_en), .nx_st(wa_st), .nx_tag(wa_tag), .nx_wtr(wa_wtr),
    .nx_data(wa_data), .o_code(c_code), .o_rdata(c_rdata), .o_req(c_req),
    .o_kind(c_kind), .o_addr(c_addr), .o_wbdata(c_wbdata)
  );

  rac_fill #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .AGENTS(AGENTS)
  ) u_fill (
    .rpl_valid(rpl_valid), .rpl_tag(rpl_tag), .rpl_data(rpl_data),
    .ent_st(b_st), .ent_tag(b_tag), .ent_wtr(b_wtr), .ent_data(b_data),
    .wr_en(wb_en), .nx_st(wb_st), .nx_data(wb_data), .o_mask(f_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= '0;
      rsp_agent  <= '0;
      rsp_data   <= '0;
      req_valid  <= 1'b0;
      req_kind   <= '0;
      req_addr   <= '0;
      req_data   <= '0;
      done_valid <= 1'b0;
      done_mask  <= '0;
      done_data  <= '0;
    end else begin
      rsp_valid  <= act;
      rsp_code   <= c_code;
      rsp_agent  <= bus_agent;
      rsp_data   <= c_rdata;
      req_valid  <= c_req;
      req_kind   <= c_kind;
      req_addr   <= c_addr;
      req_data   <= c_wbdata;
      done_valid <= wb_en;
      done_mask  <= f_mask;
      done_data  <= wb_data;
    end
  end

endmodule

// File: rtl/rac_chk.sv
module rac_chk
  import rac_pkg::*;
#(
  parameter int INDEX_W  = 8,
  parameter int AGENTS   = 4,
  parameter int CL_W     = 2,
  parameter int LOCAL_CL = 0
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_valid,
  input logic [CL_W-1:0]    bus_home,
  input logic [INDEX_W-1:0] bus_idx,
  input logic               rsp_valid,
  input logic [1:0]         rsp_code,
  input logic               req_valid,
  input logic [1:0]         req_kind,
  input logic               rpl_valid,
  input logic [INDEX_W-1:0] rpl_idx,
  input logic               done_valid,
  input logic [AGENTS-1:0]  done_mask
);
  logic remote;
  assign remote = bus_valid && (bus_home != LOCAL_CL[CL_W-1:0]);

  // R2
  remote_answered_chk: assert property (@(posedge clk) disable iff (rst)
    remote |=> rsp_valid);

  // R2
  local_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !remote |=> (!rsp_valid && !req_valid));

  // R6
  retry_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == RSP_RETRY) |-> (!req_valid || req_kind == REQ_WRBACK));

  // R12
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(rpl_valid));

  // R5
  done_has_waiter_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_mask != '0));

  // R13
  same_index_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (remote && rpl_valid && bus_idx == rpl_idx) |=> (rsp_code == RSP_RETRY));

endmodule

bind rac_top rac_chk #(
  .INDEX_W(INDEX_W), .AGENTS(AGENTS), .CL_W(CL_W), .LOCAL_CL(LOCAL_CL)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid),
  .bus_home(bus_addr[ADDR_W-1 -: CL_W]), .bus_idx(bus_addr[INDEX_W-1:0]),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .req_valid(req_valid), .req_kind(req_kind),
  .rpl_valid(rpl_valid), .rpl_idx(rpl_addr[INDEX_W-1:0]),
  .done_valid(done_valid), .done_mask(done_mask)
);

// File: tb/tb_rac_top.sv
`timescale 1ns/1ps
module tb_rac_top;
  localparam int ADDR_W = 16;
  localparam int INDEX_W = 8;
  localparam int DATA_W = 32;
  localparam int AGENTS = 4;
  localparam int DEPTH = 256;
  // model state codes
  localparam int INV = 0, PRD = 1, PWR = 2, SHR = 3, DRT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_agent = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic rpl_valid = 1'b0;
  logic [ADDR_W-1:0] rpl_addr = '0;
  logic [DATA_W-1:0] rpl_data = '0;
  logic rsp_valid, req_valid, done_valid;
  logic [1:0] rsp_code, req_kind, rsp_agent;
  logic [DATA_W-1:0] rsp_data, req_data, done_data;
  logic [ADDR_W-1:0] req_addr;
  logic [AGENTS-1:0] done_mask;

  always #2 clk = ~clk;

  rac_top dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_agent(bus_agent), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_agent(rsp_agent),
    .rsp_data(rsp_data), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .rpl_valid(rpl_valid),
    .rpl_addr(rpl_addr), .rpl_data(rpl_data), .done_valid(done_valid),
    .done_mask(done_mask), .done_data(done_data)
  );

  int total = 0, fails = 0;
  bit started = 0;

  // reference model
  int m_st [DEPTH];
  logic [7:0] m_tag [DEPTH];
  logic [3:0] m_wtr [DEPTH];
  logic [31:0] m_data [DEPTH];

  logic e_rv, e_qv, e_dv;
  logic [1:0] e_code, e_agent, e_kind;
  logic [31:0] e_rdata, e_qdata, e_ddata;
  logic [15:0] e_qaddr;
  logic [3:0] e_mask;
  string e_tag, d_tag;

  always @(posedge clk) begin
    int bi, ri, r_st, n_st;
    logic [7:0] bt, rt, n_tag;
    logic [3:0] n_wtr;
    logic [31:0] r_data, n_data;
    bit hit, bwr, rem;
    started = 1;
    e_rv = 0; e_qv = 0; e_dv = 0;
    e_code = 0; e_agent = 0; e_kind = 0;
    e_rdata = 0; e_qdata = 0; e_ddata = 0; e_qaddr = 0; e_mask = 0;
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) m_st[i] = INV;
      e_tag = "R1"; d_tag = "R1";
    end else begin
      e_tag = "R2"; d_tag = "R12";
      ri = int'(rpl_addr[7:0]); rt = rpl_addr[15:8];
      hit = rpl_valid && (m_st[ri] == PRD || m_st[ri] == PWR) && m_tag[ri] == rt;
      r_st = INV; r_data = 0;
      if (hit) begin
        if (m_st[ri] == PRD) begin r_st = SHR; r_data = rpl_data; d_tag = "R4"; end
        else begin r_st = DRT; r_data = m_data[ri]; d_tag = "R8"; end
        e_dv = 1; e_mask = m_wtr[ri]; e_ddata = r_data;
      end
      bi = int'(bus_addr[7:0]); bt = bus_addr[15:8];
      rem = bus_valid && bus_addr[15:14] != 2'd0;
      bwr = 0;
      n_st = m_st[bi]; n_tag = m_tag[bi]; n_wtr = m_wtr[bi]; n_data = m_data[bi];
      if (rem) begin
        e_rv = 1; e_code = 2; e_agent = bus_agent;
        if (rpl_valid && ri == bi) e_tag = "R13";
        else if (m_st[bi] == INV || (m_st[bi] == SHR && m_tag[bi] != bt)) begin
          bwr = 1; n_tag = bt; n_wtr = 4'b1 << bus_agent; e_code = 1;
          e_qv = 1; e_qaddr = bus_addr;
          if (bus_write) begin n_st = PWR; n_data = bus_wdata; e_kind = 1; e_tag = "R8"; end
          else begin n_st = PRD; e_kind = 0; e_tag = "R3"; end
        end else if (m_tag[bi] != bt) begin
          if (m_st[bi] == DRT) begin
            bwr = 1; n_st = INV; e_qv = 1; e_kind = 2;
            e_qaddr = {m_tag[bi], bus_addr[7:0]}; e_qdata = m_data[bi]; e_tag = "R11";
          end else e_tag = "R6";
        end else begin
          case (m_st[bi])
            SHR: if (bus_write) begin
                   bwr = 1; n_st = PWR; n_data = bus_wdata; n_wtr = 4'b1 << bus_agent;
                   e_code = 1; e_qv = 1; e_kind = 1; e_qaddr = bus_addr; e_tag = "R9";
                 end else begin e_code = 0; e_rdata = m_data[bi]; e_tag = "R4"; end
            DRT: begin
                   e_code = 0; e_tag = "R8";
                   if (bus_write) begin bwr = 1; n_data = bus_wdata; e_rdata = bus_wdata; end
                   else e_rdata = m_data[bi];
                 end
            PRD: if (!bus_write) begin
                   bwr = 1; n_wtr = m_wtr[bi] | (4'b1 << bus_agent); e_code = 1; e_tag = "R5";
                 end else e_tag = "R10";
            default: begin
                   bwr = 1; n_wtr = m_wtr[bi] | (4'b1 << bus_agent); e_code = 1; e_tag = "R5";
                   if (bus_write) n_data = bus_wdata;
                 end
          endcase
        end
      end
      if (hit) begin m_st[ri] = r_st; m_data[ri] = r_data; m_wtr[ri] = 0; end
      if (bwr) begin m_st[bi] = n_st; m_tag[bi] = n_tag; m_wtr[bi] = n_wtr; m_data[bi] = n_data; end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check(rsp_valid == e_rv && (!e_rv || {rsp_code, rsp_agent, rsp_data} == {e_code, e_agent, e_rdata}),
            e_tag, "response", {27'd0, rsp_valid, rsp_code, rsp_agent, rsp_data},
            {27'd0, e_rv, e_code, e_agent, e_rdata});
      check(req_valid == e_qv && (!e_qv || {req_kind, req_addr, req_data} == {e_kind, e_qaddr, e_qdata}),
            e_tag, "request", {13'd0, req_valid, req_kind, req_addr, req_data},
            {13'd0, e_qv, e_kind, e_qaddr, e_qdata});
      check(done_valid == e_dv && (!e_dv || {done_mask, done_data} == {e_mask, e_ddata}),
            d_tag, "completion", {27'd0, done_valid, done_mask, done_data},
            {27'd0, e_dv, e_mask, e_ddata});
    end
  end

  function automatic logic [15:0] mk(input int cl, input int t, input int idx);
    return {cl[1:0], t[5:0], idx[7:0]};
  endfunction

  task automatic step(input bit bv, input bit bw, input int ag, input logic [15:0] ba,
                      input logic [31:0] bd, input bit rv, input logic [15:0] ra,
                      input logic [31:0] rd);
    @(negedge clk);
    bus_valid = bv; bus_write = bw; bus_agent = ag[1:0]; bus_addr = ba; bus_wdata = bd;
    rpl_valid = rv; rpl_addr = ra; rpl_data = rd;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;                                             // R1 checked during reset
    step(1, 0, 0, mk(0, 3, 5), 0, 0, 0, 0);                 // R2 local ignored
    step(1, 0, 0, mk(1, 0, 5), 0, 0, 0, 0);                 // R3 read miss
    step(1, 0, 1, mk(1, 0, 5), 0, 0, 0, 0);                 // R5 merge
    step(1, 0, 2, mk(2, 0, 5), 0, 0, 0, 0);                 // R6 conflict
    step(1, 0, 2, mk(1, 0, 9), 0, 0, 0, 0);                 // R7 second outstanding
    step(1, 1, 3, mk(1, 0, 5), 32'h55, 0, 0, 0);            // R10 write to read-pending
    step(0, 0, 0, 0, 0, 1, mk(1, 0, 9), 32'hC0DE_0009);     // R7 reply out of order
    step(1, 0, 3, mk(1, 0, 5), 0, 1, mk(1, 0, 5), 32'hA5A5_0005); // R13 + R4
    step(1, 0, 3, mk(1, 0, 5), 0, 0, 0, 0);                 // R4 hit
    step(0, 0, 0, 0, 0, 1, mk(1, 0, 5), 32'hDEAD);          // R12 stale reply
    step(1, 1, 0, mk(1, 0, 5), 32'h1111_2222, 0, 0, 0);     // R9 upgrade
    step(1, 0, 1, mk(1, 0, 5), 0, 0, 0, 0);                 // R5 merge on own-pending
    step(0, 0, 0, 0, 0, 1, mk(1, 0, 5), 32'hBAD0);          // R8 reply keeps write data
    step(1, 1, 2, mk(1, 0, 5), 32'h3333, 0, 0, 0);          // R8 dirty write hit
    step(1, 0, 2, mk(2, 0, 5), 0, 0, 0, 0);                 // R11 writeback
    step(1, 0, 2, mk(2, 0, 5), 0, 0, 0, 0);                 // R11 now misses
    step(1, 1, 1, mk(3, 1, 20), 32'h7777, 0, 0, 0);         // R8 write miss
    step(0, 0, 0, 0, 0, 1, mk(3, 1, 20), 32'h0);            // R8 completion
    step(1, 0, 0, mk(3, 1, 20), 0, 0, 0, 0);                // R8 read dirty
    idle();
    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, $urandom_range(0, 3),
           mk($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3)), $urandom,
           $urandom_range(0, 2) == 0,
           mk($urandom_range(1, 3), $urandom_range(0, 1), $urandom_range(0, 3)), $urandom);
    end
    idle();
    idle();
    summary();
    $finish;
  end

endmodule